// File: doc/BRIEF.md
# Segmented Stack Address Unit

This unit turns segment-relative references into flat physical addresses and manages a word-sized hardware stack. It holds four 16-bit segment bases (code, data, stack, extra) and a 16-bit stack pointer. A general request names one of the four segments and a 16-bit offset. The unit answers one cycle later with a 20-bit physical address. That address is the segment value moved up by four bit positions, plus the offset.

Push and pop strobes move the stack pointer one 2-byte word at a time, and the unit presents the stack-segment address of the word involved. The stack grows downward from offset FFFEh. A push that would drop the pointer below a lower-limit offset is refused and raises an overflow pulse. A pop issued with the pointer already at the top is refused and raises an underflow pulse. A refused operation leaves the pointer unchanged.

Top module: `seg_stack_agu`

## Requirements
- R1: After reset all four segment bases are 0000h, `sp_out` is FFFEh, and `addr_vld`, `ovf` and `udf` are low.
- R2: A load with `ld_en` high writes `ld_val` into the target selected by `ld_sel` on the next edge. The codes are 0 for code, 1 for data, 2 for stack, 3 for extra and 4 for the stack pointer. A stack-pointer load suppresses any push or pop in the same cycle.
- R3: With no single stack strobe, `req_en` yields `phys_addr` = segment[`req_seg`] × 16 + `req_off` with `addr_vld` high on the following cycle. For example, segment 123Ah with offset 341Bh gives 157BBh.
- R4: The address sum is truncated to 20 bits, so it wraps modulo 1 MB. For example, FFFFh:FFFFh gives 0FFEFh.
- R5: An accepted push lowers `sp_out` by 2. One cycle later it presents stack-segment × 16 + (the new pointer) with `addr_vld` high.
- R6: An accepted pop presents stack-segment × 16 + (the old pointer) with `addr_vld` high, and raises `sp_out` by 2.
- R7: A push made while `sp_out` < limit + 2 (limit defaults to 0100h) is refused. `ovf` pulses for one cycle, `addr_vld` is low, and `sp_out` is unchanged.
- R8: A pop made while `sp_out` ≥ FFFEh is refused. `udf` pulses for one cycle, `addr_vld` is low, and `sp_out` is unchanged.
- R9: Push and pop high in the same cycle do nothing to the stack and raise no flag. A request in that cycle is served as in R3.
- R10: A single push or pop takes priority over `req_en` in the same cycle, and the request is dropped.
- R11: A cycle with no request and no stack strobe gives `addr_vld` low on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| ld_en | input | 1 | Load strobe |
| ld_sel | input | 3 | Load target (0..3 segment, 4 stack pointer) |
| ld_val | input | 16 | Load value |
| req_en | input | 1 | Address request strobe |
| req_seg | input | 2 | Segment used by the request |
| req_off | input | 16 | Request offset |
| push | input | 1 | Push one word |
| pop | input | 1 | Pop one word |
| phys_addr | output | 20 | Registered physical address |
| addr_vld | output | 1 | `phys_addr` was produced by the last cycle |
| sp_out | output | 16 | Current stack pointer |
| ovf | output | 1 | Refused-push pulse |
| udf | output | 1 | Refused-pop pulse |

## Verification
The overflow boundary is the hardest case to reach from the ports. Starting at FFFEh, the stack would need about 32,000 accepted pushes to descend to the limit. The stimulus therefore loads the stack pointer directly with values at the limit, two above it, four above it, and near the top. Random push and pop traffic then crosses both boundaries repeatedly. The random mix also collides single strobes with requests, double strobes and stack-pointer loads in the same cycle.

// File: rtl/seg_agu_pkg.sv
package seg_agu_pkg;

   typedef enum logic [1:0] {
      SEG_CODE  = 2'd0,
      SEG_DATA  = 2'd1,
      SEG_STACK = 2'd2,
      SEG_EXTRA = 2'd3
   } seg_id_e;

   typedef enum logic [1:0] {
      OP_IDLE,
      OP_REQ,
      OP_STACK,
      OP_REFUSE
   } agu_op_e;

endpackage

// File: rtl/seg_file.sv
module seg_file #(
   parameter int unsigned SEG_W   = 16,
   parameter int unsigned NUM_SEG = 4,
   localparam int unsigned IDX_W  = (NUM_SEG > 1) ? $clog2(NUM_SEG) : 1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     wr_en,
   input  logic [IDX_W-1:0]         wr_idx,
   input  logic [SEG_W-1:0]         wr_val,
   output logic [NUM_SEG*SEG_W-1:0] seg_flat
);

   genvar gi;
   generate
      for (gi = 0; gi < NUM_SEG; gi++) begin : g_seg
         logic [SEG_W-1:0] base_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               base_q <= '0;
            else if (wr_en && (wr_idx == IDX_W'(gi)))
               base_q <= wr_val;
         end
         assign seg_flat[gi*SEG_W +: SEG_W] = base_q;
      end
   endgenerate

endmodule

// File: rtl/addr_former.sv
module addr_former #(
   parameter int unsigned SEG_W = 16,
   parameter int unsigned OFF_W = 16,
   parameter int unsigned SHIFT = 4,
   parameter int unsigned PA_W  = 20
) (
   input  logic [SEG_W-1:0] seg,
   input  logic [OFF_W-1:0] off,
   output logic [PA_W-1:0]  pa
);

   generate
      if (SHIFT == 0) begin : g_flat
         assign pa = PA_W'(seg) + PA_W'(off);
      end else begin : g_shifted
         logic [SEG_W+SHIFT-1:0] base_ext;
         assign base_ext = {seg, {SHIFT{1'b0}}};
         assign pa       = PA_W'(base_ext) + PA_W'(off);
      end
   endgenerate

endmodule

// File: rtl/stack_ptr_unit.sv
module stack_ptr_unit #(
   parameter int unsigned SP_W    = 16,
   parameter int unsigned STEP    = 2,
   parameter int unsigned SP_TOP  = 'hFFFE,
   parameter int unsigned SP_LIM  = 'h0100
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            ld_en,
   input  logic [SP_W-1:0] ld_val,
   input  logic            push_req,
   input  logic            pop_req,
   output logic [SP_W-1:0] sp,
   output logic [SP_W-1:0] sp_dec,
   output logic            push_ok,
   output logic            pop_ok,
   output logic            push_bad,
   output logic            pop_bad
);

   localparam logic [SP_W:0]   LOW_OK = (SP_W+1)'(SP_LIM + STEP);
   localparam logic [SP_W-1:0] TOP_V  = SP_W'(SP_TOP);
   localparam logic [SP_W-1:0] STEP_V = SP_W'(STEP);

   logic [SP_W-1:0] sp_q;
   logic            below;
   logic            at_top;

   assign below    = ({1'b0, sp_q} < LOW_OK);
   assign at_top   = (sp_q >= TOP_V);
   assign sp_dec   = sp_q - STEP_V;
   assign push_ok  = push_req && !below;
   assign push_bad = push_req &&  below;
   assign pop_ok   = pop_req  && !at_top;
   assign pop_bad  = pop_req  &&  at_top;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         sp_q <= TOP_V;
      else if (ld_en)
         sp_q <= ld_val;
      else if (push_ok)
         sp_q <= sp_dec;
      else if (pop_ok)
         sp_q <= sp_q + STEP_V;
   end

   assign sp = sp_q;

endmodule

// File: rtl/seg_stack_agu.sv
module seg_stack_agu
   import seg_agu_pkg::*;
#(
   parameter int unsigned SEG_W   = 16,
   parameter int unsigned OFF_W   = 16,
   parameter int unsigned SHIFT   = 4,
   parameter int unsigned PA_W    = 20,
   parameter int unsigned NUM_SEG = 4,
   parameter int unsigned STK_IDX = 2,
   parameter int unsigned STEP    = 2,
   parameter int unsigned SP_TOP  = 'hFFFE,
   parameter int unsigned SP_LIM  = 'h0100,
   localparam int unsigned IDX_W  = (NUM_SEG > 1) ? $clog2(NUM_SEG) : 1,
   localparam int unsigned LSEL_W = $clog2(NUM_SEG + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ld_en,
   input  logic [LSEL_W-1:0] ld_sel,
   input  logic [SEG_W-1:0]  ld_val,
   input  logic              req_en,
   input  logic [IDX_W-1:0]  req_seg,
   input  logic [OFF_W-1:0]  req_off,
   input  logic              push,
   input  logic              pop,
   output logic [PA_W-1:0]   phys_addr,
   output logic              addr_vld,
   output logic [OFF_W-1:0]  sp_out,
   output logic              ovf,
   output logic              udf
);

   localparam logic [LSEL_W-1:0] SP_SEL = LSEL_W'(NUM_SEG);

   generate
      if (PA_W < SEG_W + SHIFT || PA_W < OFF_W) begin : g_bad_pa
         $error("PA_W too narrow for shifted segment or offset");
      end
      if (STK_IDX >= NUM_SEG) begin : g_bad_stk
         $error("STK_IDX outside the segment file");
      end
      if (STEP == 0 || SP_TOP >= (1 << OFF_W) || SP_LIM > SP_TOP) begin : g_bad_sp
         $error("stack pointer parameters inconsistent");
      end
   endgenerate

   logic                     ld_sp, ld_seg;
   logic                     push_one, pop_one;
   logic [NUM_SEG*SEG_W-1:0] seg_flat;
   logic [SEG_W-1:0]         req_base, stk_base;
   logic [OFF_W-1:0]         sp_cur, sp_dec, stk_off;
   logic                     push_ok, pop_ok, push_bad, pop_bad;
   logic [PA_W-1:0]          req_pa, stk_pa;
   agu_op_e                  op;

   assign ld_sp    = ld_en && (ld_sel == SP_SEL);
   assign ld_seg   = ld_en && (ld_sel < SP_SEL);
   assign push_one = push && !pop && !ld_sp;
   assign pop_one  = pop && !push && !ld_sp;

   seg_file #(
      .SEG_W   (SEG_W),
      .NUM_SEG (NUM_SEG)
   ) u_segs (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (ld_seg),
      .wr_idx   (ld_sel[IDX_W-1:0]),
      .wr_val   (ld_val),
      .seg_flat (seg_flat)
   );

   stack_ptr_unit #(
      .SP_W   (OFF_W),
      .STEP   (STEP),
      .SP_TOP (SP_TOP),
      .SP_LIM (SP_LIM)
   ) u_sp (
      .clk      (clk),
      .rst_n    (rst_n),
      .ld_en    (ld_sp),
      .ld_val   (OFF_W'(ld_val)),
      .push_req (push_one),
      .pop_req  (pop_one),
      .sp       (sp_cur),
      .sp_dec   (sp_dec),
      .push_ok  (push_ok),
      .pop_ok   (pop_ok),
      .push_bad (push_bad),
      .pop_bad  (pop_bad)
   );

   assign req_base = seg_flat[req_seg*SEG_W +: SEG_W];
   assign stk_base = seg_flat[STK_IDX*SEG_W +: SEG_W];
   assign stk_off  = push_one ? sp_dec : sp_cur;

   addr_former #(
      .SEG_W (SEG_W), .OFF_W (OFF_W), .SHIFT (SHIFT), .PA_W (PA_W)
   ) u_req_pa (
      .seg (req_base),
      .off (req_off),
      .pa  (req_pa)
   );

   addr_former #(
      .SEG_W (SEG_W), .OFF_W (OFF_W), .SHIFT (SHIFT), .PA_W (PA_W)
   ) u_stk_pa (
      .seg (stk_base),
      .off (stk_off),
      .pa  (stk_pa)
   );

   always_comb begin
      if (push_ok || pop_ok)
         op = OP_STACK;
      else if (push_bad || pop_bad)
         op = OP_REFUSE;
      else if (req_en)
         op = OP_REQ;
      else
         op = OP_IDLE;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phys_addr <= '0;
         addr_vld  <= 1'b0;
         ovf       <= 1'b0;
         udf       <= 1'b0;
      end else begin
         ovf <= push_bad;
         udf <= pop_bad;
         unique case (op)
            OP_STACK: begin
               phys_addr <= stk_pa;
               addr_vld  <= 1'b1;
            end
            OP_REQ: begin
               phys_addr <= req_pa;
               addr_vld  <= 1'b1;
            end
            default: addr_vld <= 1'b0;
         endcase
      end
   end

   assign sp_out = sp_cur;

endmodule

// File: rtl/seg_stack_agu_chk.sv
module seg_stack_agu_chk #(
   parameter int unsigned OFF_W  = 16,
   parameter int unsigned LSEL_W = 3,
   parameter int unsigned NUM_SEG = 4,
   parameter int unsigned STEP   = 2,
   parameter int unsigned SP_TOP = 'hFFFE,
   parameter int unsigned SP_LIM = 'h0100
) (
   input logic              clk,
   input logic              rst_n,
   input logic              ld_en,
   input logic [LSEL_W-1:0] ld_sel,
   input logic              req_en,
   input logic              push,
   input logic              pop,
   input logic              addr_vld,
   input logic [OFF_W-1:0]  sp_out,
   input logic              ovf,
   input logic              udf
);

   logic ld_sp, push_one, pop_one;
   assign ld_sp    = ld_en && (ld_sel == LSEL_W'(NUM_SEG));
   assign push_one = push && !pop && !ld_sp;
   assign pop_one  = pop && !push && !ld_sp;

   a_r5_push_step: assert property (@(posedge clk) disable iff (!rst_n)
      (push_one && ({1'b0, sp_out} >= (OFF_W+1)'(SP_LIM + STEP)))
      |=> (sp_out == OFF_W'($past(sp_out) - STEP)) && addr_vld);

   a_r6_pop_step: assert property (@(posedge clk) disable iff (!rst_n)
      (pop_one && (sp_out < OFF_W'(SP_TOP)))
      |=> (sp_out == OFF_W'($past(sp_out) + STEP)) && addr_vld);

   a_r7_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      (push_one && ({1'b0, sp_out} < (OFF_W+1)'(SP_LIM + STEP)))
      |=> ovf && !addr_vld && $stable(sp_out));

   a_r8_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
      (pop_one && (sp_out >= OFF_W'(SP_TOP)))
      |=> udf && !addr_vld && $stable(sp_out));

   a_r9_both_strobes: assert property (@(posedge clk) disable iff (!rst_n)
      (push && pop && !ld_sp) |=> $stable(sp_out) && !ovf && !udf);

   a_r11_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (!push && !pop && !req_en) |=> !addr_vld);

   a_r7_flags_apart: assert property (@(posedge clk) disable iff (!rst_n)
      !(ovf && udf));

endmodule

bind seg_stack_agu seg_stack_agu_chk #(
   .OFF_W   (OFF_W),
   .LSEL_W  (LSEL_W),
   .NUM_SEG (NUM_SEG),
   .STEP    (STEP),
   .SP_TOP  (SP_TOP),
   .SP_LIM  (SP_LIM)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .ld_en    (ld_en),
   .ld_sel   (ld_sel),
   .req_en   (req_en),
   .push     (push),
   .pop      (pop),
   .addr_vld (addr_vld),
   .sp_out   (sp_out),
   .ovf      (ovf),
   .udf      (udf)
);

// File: tb/sim_seg_stack_agu.sv
module sim_seg_stack_agu;

   localparam logic [15:0] LIM = 16'h0100;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ld_en = 0, req_en = 0, push = 0, pop = 0;
   logic [2:0]  ld_sel = 0;
   logic [15:0] ld_val = 0, req_off = 0;
   logic [1:0]  req_seg = 0;
   logic [19:0] phys_addr;
   logic        addr_vld, ovf, udf;
   logic [15:0] sp_out;

   int checks = 0;
   int errors = 0;
   logic [15:0] m_seg [4];
   logic [15:0] m_sp;

   always #2 clk = ~clk;

   seg_stack_agu u0 (
      .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_sel(ld_sel), .ld_val(ld_val),
      .req_en(req_en), .req_seg(req_seg), .req_off(req_off), .push(push), .pop(pop),
      .phys_addr(phys_addr), .addr_vld(addr_vld), .sp_out(sp_out), .ovf(ovf), .udf(udf)
   );

   function automatic logic [19:0] pa(input logic [15:0] s, input logic [15:0] o);
      logic [19:0] r;
      r = {s, 4'h0} + {4'h0, o};
      return r;
   endfunction

   task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
      end
   endtask

   task automatic step(input logic l_en, input logic [2:0] l_sel, input logic [15:0] l_val,
                       input logic r_en, input logic [1:0] r_seg, input logic [15:0] r_off,
                       input logic pu, input logic po);
      logic        l_sp, e_vld, e_ovf, e_udf;
      logic [19:0] e_pa;
      string       tag;
      ld_en = l_en; ld_sel = l_sel; ld_val = l_val;
      req_en = r_en; req_seg = r_seg; req_off = r_off; push = pu; pop = po;
      l_sp = l_en && (l_sel == 3'd4);
      e_vld = 0; e_ovf = 0; e_udf = 0; e_pa = '0; tag = "R11";
      if (!l_sp && pu && !po) begin
         if (m_sp < LIM + 16'd2) begin e_ovf = 1; tag = "R7"; end
         else begin
            m_sp = m_sp - 16'd2; e_vld = 1; e_pa = pa(m_seg[2], m_sp);
            tag = r_en ? "R10" : "R5";
         end
      end else if (!l_sp && po && !pu) begin
         if (m_sp >= 16'hFFFE) begin e_udf = 1; tag = "R8"; end
         else begin
            e_vld = 1; e_pa = pa(m_seg[2], m_sp); m_sp = m_sp + 16'd2;
            tag = r_en ? "R10" : "R6";
         end
      end else if (r_en) begin
         e_vld = 1; e_pa = pa(m_seg[r_seg], r_off);
         tag = (pu && po) ? "R9" : "R3";
      end
      if (l_sp) m_sp = l_val;
      else if (l_en && l_sel < 3'd4) m_seg[l_sel[1:0]] = l_val;
      @(posedge clk); #1;
      chk(tag, "addr_vld", addr_vld, e_vld);
      if (e_vld) chk(tag, "phys_addr", phys_addr, e_pa);
      chk(tag, "ovf", ovf, e_ovf);
      chk(tag, "udf", udf, e_udf);
      chk(l_sp ? "R2" : tag, "sp_out", sp_out, m_sp);
   endtask

   initial begin
      #(4 * 200000);
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      logic [15:0] picks [6];
      void'($urandom(32'd20240611));
      for (int i = 0; i < 4; i++) m_seg[i] = 16'h0;
      m_sp = 16'hFFFE;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      // R1: reset state
      chk("R1", "sp_out", sp_out, 16'hFFFE);
      chk("R1", "addr_vld", addr_vld, 0);
      chk("R1", "ovf", ovf, 0);
      chk("R1", "udf", udf, 0);
      step(0, 0, 0, 1, 2'd3, 16'h1234, 0, 0);
      chk("R1", "extra segment zero", phys_addr, 20'h01234);
      // R8: pop at top refused
      step(0, 0, 0, 0, 0, 0, 0, 1);
      // R2 + R3: data segment load and documented example
      step(1, 3'd1, 16'h123A, 0, 0, 0, 0, 0);
      step(0, 0, 0, 1, 2'd1, 16'h341B, 0, 0);
      chk("R3", "example", phys_addr, 20'h157BB);
      // R4: wrap modulo 1 MB
      step(1, 3'd3, 16'hFFFF, 0, 0, 0, 0, 0);
      step(0, 0, 0, 1, 2'd3, 16'hFFFF, 0, 0);
      chk("R4", "wrap", phys_addr, 20'h0FFEF);
      // R5 / R6: push then pop on stack segment 2000h
      step(1, 3'd2, 16'h2000, 0, 0, 0, 0, 0);
      step(0, 0, 0, 0, 0, 0, 1, 0);
      chk("R5", "push addr", phys_addr, 20'h2FFFC);
      step(0, 0, 0, 0, 0, 0, 0, 1);
      chk("R6", "pop addr", phys_addr, 20'h2FFFC);
      // R2 + R7: pointer near limit
      step(1, 3'd4, LIM + 16'd2, 0, 0, 0, 1, 0);
      step(0, 0, 0, 0, 0, 0, 1, 0);
      step(0, 0, 0, 1, 2'd0, 16'h0042, 1, 0);
      chk("R7", "sp held at limit", sp_out, LIM);
      // R9: both strobes with request
      step(0, 0, 0, 1, 2'd2, 16'h0010, 1, 1);
      // R11: idle
      step(0, 0, 0, 0, 0, 0, 0, 0);
      // random traffic
      picks[0] = LIM; picks[1] = LIM + 16'd2; picks[2] = LIM + 16'd4;
      picks[3] = 16'hFFFE; picks[4] = 16'hFFFC; picks[5] = 16'h8000;
      for (int n = 0; n < 4000; n++) begin
         logic        le, re, pu, po;
         logic [2:0]  ls;
         logic [15:0] lv;
         le = ($urandom % 100) < 12;
         ls = 3'($urandom % 5);
         lv = 16'($urandom);
         if (ls == 3'd4) lv = ($urandom % 2) ? picks[$urandom % 6] : (lv & 16'hFFFE);
         re = ($urandom % 2) == 1;
         pu = ($urandom % 3) == 0;
         po = ($urandom % 3) == 0;
         step(le, ls, lv, re, 2'($urandom), 16'($urandom), pu, po);
      end
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule